// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Unit

This block holds two independent 32-bit down-counting timers behind a word-wide register interface. Each timer has a divisor register, a control register and a data register that reads back its live count. A control write selects a tick source and one of three operations: load the divisor into the counter, hold the counter, or let it run. A running timer counts one step on each tick of its selected source. When it expires it reloads its divisor and keeps counting, so it fires periodically.

Expiries land in a shared status register. A mask register gates the status bits onto a single interrupt line. Software clears status bits through a write-one-to-clear acknowledge register. A separate free-running time counter advances on the fastest tick source. Clock sources are modelled as single-cycle tick-enable inputs, not as separate clocks.

Each timer is built around a two-state machine. In STOP the counter is frozen. In RUN it advances on selected ticks. There are two transitions: STOP to RUN on a valid run operation, and RUN to STOP on a valid hold operation. A load operation changes the count but does not change the state.

Top module: `dtmr_top`

## Requirements
- R1: After reset both timers are in STOP with count 0. Status, mask, the time counter and `irq` are all 0.
- R2: A control write (offset 0x08 for timer 0, 0x18 for timer 1) with operation bits [1:0]=0 (load) copies the divisor (offset 0x00 / 0x10) into the counter. The count reads back at offset 0x04 / 0x14 on the next cycle.
- R3: Operation 1 (hold) moves the timer to STOP. In STOP the count does not change on any tick.
- R4: Operation 2 (run) moves the timer to RUN. Control bits [4:2] select the tick source. Codes 4, 5, 6 and 7 select `tick_src[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 select no source, so the count stays still. Each selected tick decrements the count by one.
- R5: A tick that finds a running count of 0 or 1 reloads the divisor and sets the status bit. Timer 0 sets bit 0 and timer 1 sets bit 1. The period is therefore the divisor value in ticks.
- R6: A control write with operation code 3 is ignored entirely. The control readback, the state and the count do not change.
- R7: The masked status (offset 0x54) reads as status (offset 0x50) AND mask (offset 0x48, bits [1:0]). `irq` is high exactly when any masked bit is set. It follows a mask write on the next cycle.
- R8: A write to the acknowledge register (offset 0x4C) clears each status bit written as 1 and leaves the others unchanged. An expiry in the same cycle as the acknowledge of its bit leaves that bit set.
- R9: The time counter (offset 0x38) increments by one on each cycle in which `tick_src[3]` is high.
- R10: Only full-word accesses act. A write with `bus_be` not equal to 4'hF changes nothing. A read with `bus_be` not equal to 4'hF returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; only 4'hF acts |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_src | input | 4 | One-cycle tick enables of the four sources |
| irq | output | 1 | OR of masked status bits |

## Verification
A timer stuck in the wrong state shows up at its data register on the first selected tick after the offending control write. The count either moves when it should be frozen or stays still when it should count. A wrong reload or a wrong expiry threshold changes the data readback and the status bit on the tick that should expire the timer. The period sweep therefore catches it within one divisor period. Status, mask or acknowledge errors appear on `irq` and on the masked view one cycle after the write that exposes them.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int TMR_N      = 2;
    localparam int TMR_STRIDE = 16;
    localparam int OFS_DIV    = 0;
    localparam int OFS_DATA   = 4;
    localparam int OFS_CTRL   = 8;
    localparam int OFS_TIME   = 'h38;
    localparam int OFS_MASK   = 'h48;
    localparam int OFS_ACK    = 'h4C;
    localparam int OFS_RAW    = 'h50;
    localparam int OFS_MSKD   = 'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } tmr_op_e;

    typedef enum logic {
        TS_STOP = 1'b0,
        TS_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/dtmr_timer.sv
module dtmr_timer
    import dtmr_pkg::*;
#(
    parameter int W     = 32,
    parameter int SEL_W = 3,
    localparam int IDX_W  = SEL_W - 1,
    localparam int SRC_N  = 2 ** IDX_W,
    localparam int CTRL_W = 2 + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic              ctrl_we,
    input  logic [W-1:0]      wdata,
    input  logic [SRC_N-1:0]  tick_src,
    output logic [W-1:0]      div_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [W-1:0]      count_q,
    output logic              running,
    output logic              expire
);

    tmr_state_e state_q, state_d;
    tmr_op_e    op;
    logic       op_ok;
    logic       tick;
    logic       adv;
    logic       at_end;
    logic [IDX_W-1:0] sel_idx;

    assign op      = tmr_op_e'(wdata[1:0]);
    assign op_ok   = ctrl_we && (op != OP_BAD);
    assign sel_idx = ctrl_q[2 +: IDX_W];

    always_comb begin
        tick = 1'b0;
        if (ctrl_q[CTRL_W-1]) begin
            tick = tick_src[sel_idx];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_STOP: if (op_ok && op == OP_RUN)  state_d = TS_RUN;
            TS_RUN:  if (op_ok && op == OP_HOLD) state_d = TS_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        adv     = (state_q == TS_RUN) && !op_ok && tick;
        at_end  = (count_q <= W'(1));
        running = (state_q == TS_RUN);
        expire  = adv && at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            ctrl_q  <= '0;
            count_q <= '0;
        end else begin
            if (div_we) begin
                div_q <= wdata;
            end
            if (op_ok) begin
                ctrl_q <= wdata[CTRL_W-1:0];
            end
            if (op_ok && op == OP_LOAD) begin
                count_q <= div_q;
            end else if (adv) begin
                count_q <= at_end ? div_q : count_q - W'(1);
            end
        end
    end

endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         ack_we,
    input  logic         mask_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] sts_q,
    output logic [N-1:0] msk_q,
    output logic         irq
);

    logic [N-1:0] clr;

    assign clr = ack_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            msk_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr) | set;
            if (mask_we) begin
                msk_q <= wdata;
            end
        end
    end

    assign irq = |(sts_q & msk_q);

endmodule

// File: rtl/dtmr_timebase.sv
module dtmr_timebase #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] time_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (tick) begin
            time_q <= time_q + W'(1);
        end
    end

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 3,
    localparam int BE_W   = W / 8,
    localparam int SRC_N  = 2 ** (SEL_W - 1),
    localparam int CTRL_W = 2 + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [SRC_N-1:0]  tick_src,
    output logic              irq
);

    logic                          full;
    logic                          wr_ok;
    logic [TMR_N-1:0]              div_we;
    logic [TMR_N-1:0]              ctrl_we;
    logic [TMR_N-1:0][W-1:0]       div_q;
    logic [TMR_N-1:0][CTRL_W-1:0]  ctrl_q;
    logic [TMR_N-1:0][W-1:0]       cnt_q;
    logic [TMR_N-1:0]              run_q;
    logic [TMR_N-1:0]              expire;
    logic [TMR_N-1:0]              sts_q;
    logic [TMR_N-1:0]              msk_q;
    logic [W-1:0]                  time_q;
    logic                          ack_we;
    logic                          mask_we;

    assign full    = (bus_be == {BE_W{1'b1}});
    assign wr_ok   = bus_wr && full;
    assign ack_we  = wr_ok && (bus_addr == ADDR_W'(OFS_ACK));
    assign mask_we = wr_ok && (bus_addr == ADDR_W'(OFS_MASK));

    for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * TMR_STRIDE);

        assign div_we[i]  = wr_ok && (bus_addr == BASE + ADDR_W'(OFS_DIV));
        assign ctrl_we[i] = wr_ok && (bus_addr == BASE + ADDR_W'(OFS_CTRL));

        dtmr_timer #(
            .W     (W),
            .SEL_W (SEL_W)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_we   (div_we[i]),
            .ctrl_we  (ctrl_we[i]),
            .wdata    (bus_wdata),
            .tick_src (tick_src),
            .div_q    (div_q[i]),
            .ctrl_q   (ctrl_q[i]),
            .count_q  (cnt_q[i]),
            .running  (run_q[i]),
            .expire   (expire[i])
        );
    end

    dtmr_irq #(
        .N (TMR_N)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (expire),
        .ack_we  (ack_we),
        .mask_we (mask_we),
        .wdata   (bus_wdata[TMR_N-1:0]),
        .sts_q   (sts_q),
        .msk_q   (msk_q),
        .irq     (irq)
    );

    dtmr_timebase #(
        .W (W)
    ) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_src[SRC_N-1]),
        .time_q (time_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (full) begin
            for (int i = 0; i < TMR_N; i++) begin
                if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFS_DIV))  bus_rdata = div_q[i];
                if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFS_DATA)) bus_rdata = cnt_q[i];
                if (bus_addr == ADDR_W'(i * TMR_STRIDE + OFS_CTRL)) bus_rdata = W'(ctrl_q[i]);
            end
            if (bus_addr == ADDR_W'(OFS_TIME)) bus_rdata = time_q;
            if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = W'(msk_q);
            if (bus_addr == ADDR_W'(OFS_RAW))  bus_rdata = W'(sts_q);
            if (bus_addr == ADDR_W'(OFS_MSKD)) bus_rdata = W'(sts_q & msk_q);
        end
    end

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W/8-1:0]    bus_be,
    input logic [W-1:0]      bus_wdata,
    input logic              tick_last,
    input logic [1:0]        sts,
    input logic [1:0]        msk,
    input logic [1:0]        expire,
    input logic [W-1:0]      time_q,
    input logic [CTRL_W-1:0] ctrl0,
    input logic [W-1:0]      cnt0,
    input logic              run0
);

    logic full;
    assign full = (bus_be == {(W/8){1'b1}});

    // R8: acknowledge of bit 0 without a concurrent expiry clears it
    a_r8_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && full && bus_addr == ADDR_W'(OFS_ACK) && bus_wdata[0] && !expire[0])
        |=> !sts[0]);

    // R8 / R5: an expiry always leaves its status bit set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |=> sts[0]);

    // R6: an illegal operation code changes neither control nor state
    a_r6_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && full && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[1:0] == 2'd3)
        |=> ($stable(ctrl0) && $stable(run0)));

    // R3: a stopped timer without a control write keeps its count
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !(bus_wr && bus_addr == ADDR_W'(OFS_CTRL)))
        |=> $stable(cnt0));

    // R9: time counter steps once per fastest-source tick
    a_r9_time: assert property (@(posedge clk) disable iff (!rst_n)
        tick_last |=> (time_q == $past(time_q) + W'(1)));

    // R10: partial-width writes leave mask and control untouched
    a_r10_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !full) |=> ($stable(msk) && $stable(ctrl0)));

endmodule

bind dtmr_top dtmr_checker #(
    .W      (W),
    .ADDR_W (ADDR_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .tick_last (tick_src[SRC_N-1]),
    .sts       (sts_q),
    .msk       (msk_q),
    .expire    (expire),
    .time_q    (time_q),
    .ctrl0     (ctrl_q[0]),
    .cnt0      (cnt_q[0]),
    .run0      (run_q[0])
);

// File: tb/dtmr_top_test.sv
`timescale 1ns/1ps
module dtmr_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int exp_time = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dtmr_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_src  (tick_src),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        bus_be = 4'hF;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        tick_src = m;
        if (m[3]) exp_time++;
        @(negedge clk);
        tick_src = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  base;
        int          c;
        int          nexp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, v); check("R1 data0", v, 0);
        rd(8'h14, v); check("R1 data1", v, 0);
        rd(8'h50, v); check("R1 status", v, 0);
        rd(8'h48, v); check("R1 mask", v, 0);
        rd(8'h38, v); check("R1 time", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R10 partial accesses
        wr(8'h00, 32'd9, 4'h3);
        wr(8'h08, 32'h10, 4'h1);
        rd(8'h04, v); check("R10 partial write ignored", v, 0);
        rd(8'h00, v); check("R10 divisor untouched", v, 0);
        wr(8'h00, 32'd9);
        rd(8'h00, v, 4'h7); check("R10 partial read zero", v, 0);
        rd(8'h00, v); check("R10 full read", v, 9);

        // R2/R3/R4 sweep over both timers and every clock code
        for (int t = 0; t < 2; t++) begin
            base = 8'(t * 16);
            for (int code = 0; code < 8; code++) begin
                wr(base, 32'd5);
                wr(base + 8'h08, 32'((code << 2) | 0));
                rd(base + 8'h04, v); check("R2 load", v, 5);
                wr(base + 8'h08, 32'((code << 2) | 2));
                for (int s = 0; s < 4; s++) pulse(4'(1 << s));
                rd(base + 8'h04, v);
                check("R4 run one tick per selected source", v, (code >= 4) ? 4 : 5);
                wr(base + 8'h08, 32'((code << 2) | 1));
                pulse(4'hF);
                pulse(4'hF);
                rd(base + 8'h04, v);
                check("R3 hold frozen", v, (code >= 4) ? 4 : 5);
            end
        end
        rd(8'h50, v); check("R5 no expiry in sweep", v, 0);

        // R5 period sweep on timer 0, source 0, several divisors
        for (int d = 1; d <= 4; d++) begin
            wr(8'h4C, 32'h3);
            wr(8'h00, 32'(d));
            wr(8'h08, 32'((4 << 2) | 0));
            wr(8'h08, 32'((4 << 2) | 2));
            c = d; nexp = 0;
            for (int k = 0; k < 2 * d + 1; k++) begin
                pulse(4'h1);
                if (c <= 1) begin c = d; nexp++; end else c--;
                rd(8'h04, v); check("R5 count", v, 32'(c));
                rd(8'h50, v); check("R5 status bit0", v, (nexp > 0) ? 1 : 0);
            end
            check("R7 irq low while masked off", {31'b0, irq}, 0);
        end

        // R7 mask
        wr(8'h48, 32'h1);
        check("R7 irq after mask", {31'b0, irq}, 1);
        rd(8'h54, v); check("R7 masked view", v, 1);

        // R8 selective ack
        wr(8'h4C, 32'h2);
        rd(8'h50, v); check("R8 other bit kept", v, 1);
        wr(8'h4C, 32'h1);
        rd(8'h50, v); check("R8 bit0 cleared", v, 0);
        check("R8 irq drops", {31'b0, irq}, 0);

        // R5 timer 1 on source 3, divisor 1: expires every tick
        wr(8'h08, 32'((4 << 2) | 1));
        wr(8'h10, 32'd1);
        wr(8'h18, 32'((7 << 2) | 0));
        wr(8'h18, 32'((7 << 2) | 2));
        pulse(4'h8);
        rd(8'h50, v); check("R5 timer1 sets bit1", v, 2);
        rd(8'h14, v); check("R5 timer1 reload", v, 1);
        rd(8'h54, v); check("R7 bit1 masked off", v, 0);
        check("R7 irq off for bit1", {31'b0, irq}, 0);
        wr(8'h48, 32'h3);
        check("R7 irq on for bit1", {31'b0, irq}, 1);

        // R8 set wins over clear in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'h2; tick_src = 4'h8;
        exp_time++;
        @(negedge clk);
        bus_wr = 1'b0; tick_src = '0;
        rd(8'h50, v); check("R8 set wins", v, 2);
        wr(8'h4C, 32'h2);
        rd(8'h50, v); check("R8 ack clears bit1", v, 0);

        // R6 illegal op ignored
        wr(8'h18, 32'((5 << 2) | 3));
        rd(8'h18, v); check("R6 control unchanged", v, 32'((7 << 2) | 2));
        pulse(4'h8);
        rd(8'h50, v); check("R6 still running", v, 2);
        wr(8'h10, 32'd7);
        wr(8'h18, 32'((7 << 2) | 1));
        wr(8'h18, 32'((7 << 2) | 3));
        rd(8'h14, v); check("R6 no load on code 3", v, 1);

        // R9 time counter
        rd(8'h38, v); check("R9 time count", v, 32'(exp_time));
        pulse(4'h7);
        rd(8'h38, v); check("R9 other sources ignored", v, 32'(exp_time));
        pulse(4'h8);
        rd(8'h38, v); check("R9 time step", v, 32'(exp_time));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule